// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a bus-attached watchdog. A fixed divide-by-32 prescaler drives a tick counter. The counter expires after a power-of-two number of ticks, and that number is chosen by a programmable exponent field. Software keeps the system alive by writing one 16-bit magic value into the upper half of the control word. Any other write leaves the count where it is.

When the count expires, the block raises a reset request for one clock and records the event in a sticky status flag. The counter then parks at zero until software either restarts it with the key or re-enables the watchdog.

Both registers can be written in three ways: a plain write, a bit-set alias and a bit-clear alias. In the cycle right after the watchdog is switched off, the block ignores every bus access.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the control word reads 0x0000_0040 (the clock identifier at bits 7:6 equals 1), the status word reads 0, and `wdt_reset_req` is low.
- R2: The control word sits at byte offset 0x00. Its fields are the enable at bit 15, the exponent PS at bits 12:8, the window flag at bit 0 and the read-only clock identifier at bits 7:6. A plain write changes only the writable bits in the byte lanes whose strobe is set. All other bits read as 0.
- R3: The set alias is at register offset +0x4 and the clear alias is at +0x8. Writing ones through the set alias sets those bits, and writing ones through the clear alias clears them. All other bits keep their value. This applies to both registers.
- R4: The reset request rises exactly 32·2^PS clock cycles after the edge that enables the watchdog or restarts it.
- R5: The count restarts when 0x5743 is written as a 16-bit access to the upper half of the control word: byte strobes 4'b1100, data bits 31:16, at byte address 0x02 or 0x00. This resets both the prescaler and the counter. No other access with a nonzero address bit 1 or bit 0 has any effect.
- R6: A different value in the upper half-word has no effect on the count. So does the key value when it arrives as part of a 32-bit write.
- R7: When the enable changes from 0 to 1, the prescaler and the counter restart from zero.
- R8: The reset request is high for exactly one cycle per expiry. Afterwards the counter holds at zero and does not expire again until it is keyed or re-enabled.
- R9: Bit 4 of the status word (offset 0x10) is set on expiry and stays set until it is cleared, for example through the clear alias at 0x18. An expiry in the same cycle as a clear leaves the flag set.
- R10: Every bus write in the cycle right after the enable bit falls is ignored.
- R11: While the enable is 0, the prescaler and the counter do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte-lane strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| wdt_reset_req | output | 1 | One-cycle reset request on expiry |

## Verification
The expiry timing is measured with two exponents: PS=2, which checks the prescaler and counter multiplication, and PS=0, which checks the single-tick corner.

Restart sources are tried one at a time against a fixed expected expiry cycle:
- a repeated correct key,
- a wrong key,
- the key inside a full-word write,
- an off/on cycle.

A restart that does not happen moves the pulse earlier. A spurious restart moves it later. The scoreboard tells both apart from the correct behaviour.

Two further cases are placed on exact cycles: a status clear that lands on the expiry edge, and a write that lands in the blackout cycle.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  typedef enum logic [1:0] {
    ACC_PLAIN = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLR   = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  localparam int unsigned EN_POS   = 15;
  localparam int unsigned WIN_POS  = 0;
  localparam int unsigned CS_LSB   = 6;
  localparam int unsigned PS_LSB   = 8;
  localparam int unsigned FLAG_POS = 4;

  // Expand four byte strobes into a 32-bit lane mask.
  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  // Apply one access of the given kind to a register word.
  function automatic logic [31:0] apply_access(input logic [31:0] cur,
                                               input logic [31:0] data,
                                               input logic [3:0]  be,
                                               input acc_kind_e   kind,
                                               input logic [31:0] wmask);
    logic [31:0] m;
    m = lane_mask(be) & wmask;
    case (kind)
      ACC_PLAIN: return (cur & ~m) | (data & m);
      ACC_SET:   return cur | (data & m);
      ACC_CLR:   return cur & ~(data & m);
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/kwdt_busdec.sv
module kwdt_busdec
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [15:0] KEY    = 16'h5743
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [3:0]        be,
  input  logic [15:0]       wdata_hi,
  input  logic              blackout,
  output acc_kind_e         ctrl_kind,
  output acc_kind_e         stat_kind,
  output logic              key_hit,
  output logic              rd_ctrl,
  output logic              rd_stat
);

  logic [2:0] word;
  logic       in_range;
  logic       aligned;
  logic       wr_ok;
  logic       key_form;

  assign word     = addr[4:2];
  assign in_range = (addr[ADDR_W-1:5] == '0);
  assign aligned  = (addr[1:0] == 2'b00);
  assign wr_ok    = we && in_range && aligned && !blackout;

  // Half-word key: strobes on the upper lanes only, byte address 0x00 or 0x02.
  assign key_form = we && in_range && (word == 3'd0) && !addr[0] &&
                    (be == 4'b1100) && (wdata_hi == KEY);
  assign key_hit  = key_form && !blackout;

  assign ctrl_kind = (wr_ok && !word[2]) ? acc_kind_e'(word[1:0]) : ACC_NONE;
  assign stat_kind = (wr_ok &&  word[2]) ? acc_kind_e'(word[1:0]) : ACC_NONE;

  assign rd_ctrl = in_range && aligned && (word == 3'd0);
  assign rd_stat = in_range && aligned && (word == 3'd4);

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int unsigned PS_W  = 5,
  parameter logic [1:0]  CS_ID = 2'd1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  acc_kind_e       ctrl_kind,
  input  acc_kind_e       stat_kind,
  input  logic [3:0]      be,
  input  logic [31:0]     wdata,
  input  logic            rd_ctrl,
  input  logic            rd_stat,
  input  logic            expire,
  output logic            on_q,
  output logic [PS_W-1:0] ps_q,
  output logic            on_rise,
  output logic            blackout,
  output logic [31:0]     rdata
);

  localparam logic [31:0] PS_FIELD = 32'(((1 << PS_W) - 1) << PS_LSB);
  localparam logic [31:0] CTRL_WM  = PS_FIELD | (32'd1 << EN_POS) | (32'd1 << WIN_POS);
  localparam logic [31:0] FLAG_M   = 32'd1 << FLAG_POS;
  localparam logic [31:0] CS_WORD  = 32'(CS_ID) << CS_LSB;

  logic [31:0] ctrl_q, ctrl_next;
  logic [31:0] stat_q, stat_next;
  logic        on_fall;

  always_comb begin
    ctrl_next = apply_access(ctrl_q, wdata, be, ctrl_kind, CTRL_WM);
    stat_next = apply_access(stat_q, wdata, be, stat_kind, FLAG_M);
    if (expire) stat_next = stat_next | FLAG_M;   // expiry wins over a clear
  end

  assign on_rise =  ctrl_next[EN_POS] && !ctrl_q[EN_POS];
  assign on_fall = !ctrl_next[EN_POS] &&  ctrl_q[EN_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      stat_q   <= '0;
      blackout <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_next;
      stat_q   <= stat_next;
      blackout <= on_fall;
    end
  end

  assign on_q = ctrl_q[EN_POS];
  assign ps_q = ctrl_q[PS_LSB +: PS_W];

  always_comb begin
    rdata = '0;
    if (!blackout) begin
      if (rd_ctrl)      rdata = ctrl_q | CS_WORD;
      else if (rd_stat) rdata = stat_q;
    end
  end

  // R9: an expiry always leaves the flag set
  assert_flag_on_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat_q[FLAG_POS]);

  // R9: only a plain write or a clear may drop the flag
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[FLAG_POS] && (stat_kind == ACC_SET || stat_kind == ACC_NONE)) |=> stat_q[FLAG_POS]);

  // R10: nothing changes in the cycle after the enable fell
  assert_blackout_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blackout |=> ($stable(ctrl_q) && $stable(stat_q)));

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int unsigned PS_W     = 5,
  parameter int unsigned PRE_LOG2 = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [PS_W-1:0] ps,
  output logic            expire,
  output logic            rst_req
);

  localparam int unsigned CNT_W = 1 << PS_W;

  logic [PRE_LOG2-1:0] pre_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                halt_q;
  logic                tick;
  logic [CNT_W-1:0]    last_idx;

  // Index of the final tick for exponent p: 2^p - 1.
  function automatic logic [CNT_W-1:0] final_tick(input logic [PS_W-1:0] p);
    return (CNT_W'(1) << p) - CNT_W'(1);
  endfunction

  assign last_idx = final_tick(ps);
  assign tick     = &pre_q;
  assign expire   = run && !halt_q && !restart && tick && (cnt_q >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      halt_q  <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire;
      if (restart) begin
        pre_q  <= '0;
        cnt_q  <= '0;
        halt_q <= 1'b0;
      end else if (run && !halt_q) begin
        pre_q <= pre_q + 1'b1;
        if (tick) begin
          if (expire) begin
            cnt_q  <= '0;
            halt_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  // R5 / R7: a restart leaves both stages at zero
  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && pre_q == '0));

  // R8: after expiry the count is parked at zero
  assert_parked_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !restart) |=> (cnt_q == '0));

  // R11: no advance while disabled
  assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> ($stable(cnt_q) && $stable(pre_q)));

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned PS_W     = 5,
  parameter int unsigned PRE_LOG2 = 5,
  parameter logic [1:0]  CS_ID    = 2'd1,
  parameter logic [15:0] KEY      = 16'h5743
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_reset_req
);

  acc_kind_e       ctrl_kind, stat_kind;
  logic            key_hit, rd_ctrl, rd_stat;
  logic            blackout, on_q, on_rise, expire, restart;
  logic [PS_W-1:0] ps_q;

  kwdt_busdec #(.ADDR_W(ADDR_W), .KEY(KEY)) u_dec (
    .addr(bus_addr), .we(bus_we), .be(bus_be), .wdata_hi(bus_wdata[31:16]),
    .blackout(blackout), .ctrl_kind(ctrl_kind), .stat_kind(stat_kind),
    .key_hit(key_hit), .rd_ctrl(rd_ctrl), .rd_stat(rd_stat)
  );

  kwdt_regs #(.PS_W(PS_W), .CS_ID(CS_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_kind(ctrl_kind), .stat_kind(stat_kind),
    .be(bus_be), .wdata(bus_wdata), .rd_ctrl(rd_ctrl), .rd_stat(rd_stat),
    .expire(expire), .on_q(on_q), .ps_q(ps_q), .on_rise(on_rise),
    .blackout(blackout), .rdata(bus_rdata)
  );

  // R5 key and R7 enable edge both restart; R6 other writes never reach here
  assign restart = key_hit || on_rise;

  kwdt_counter #(.PS_W(PS_W), .PRE_LOG2(PRE_LOG2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(on_q), .restart(restart), .ps(ps_q),
    .expire(expire), .rst_req(wdt_reset_req)
  );

  // R8: the request is a single-cycle pulse
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |=> !wdt_reset_req);

  // R4: a request is only raised while enabled
  assert_req_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> on_q);

endmodule

// File: tb/kwdt_top_bench.sv
module kwdt_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rreq;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  kwdt_top u_kwdt_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_be(be),
    .bus_wdata(wdata), .bus_rdata(rdata), .wdt_reset_req(rreq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Monitor: pop expected expiry cycles as pulses appear.
  always @(negedge clk) begin
    int e;
    if (rst_n && !done) begin
      if (rreq) begin
        if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected reset request at cycle", cyc, 0);
        else begin
          e = exp_q.pop_front();
          chk(cyc == e, "R4", "reset request cycle", cyc, e);
        end
      end else if (exp_q.size() != 0 && exp_q[0] < cyc) begin
        e = exp_q.pop_front();
        chk(1'b0, "R4", "missed reset request, now at cycle", cyc, e);
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [3:0] b,
                        input logic [31:0] d, output int c);
    addr = a; be = b; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; be = '0;
    c = cyc;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] expv,
                        input string req, input string what);
    addr = a; we = 1'b0;
    #1;
    chk(rdata == expv, req, what, rdata, expv);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    summary();
    $finish;
  end

  initial begin
    int c, c2;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    bus_rd(8'h00, 32'h0000_0040, "R1", "control after reset");
    bus_rd(8'h10, 32'h0, "R1", "status after reset");
    chk(rreq == 1'b0, "R1", "request after reset", rreq, 0);

    // R2 plain writes honour strobes and writable bits
    bus_wr(8'h00, 4'b0001, 32'hFFFF_FFFF, c);
    bus_rd(8'h00, 32'h0000_0041, "R2", "window bit via lane 0");
    bus_wr(8'h00, 4'b0010, 32'h0000_0300, c);
    bus_rd(8'h00, 32'h0000_0341, "R2", "exponent via lane 1");
    bus_wr(8'h00, 4'b0001, 32'hFFFF_FFC0, c);
    bus_rd(8'h00, 32'h0000_0340, "R2", "clock id is read-only");

    // R3 set/clear aliases on control
    bus_wr(8'h08, 4'b1111, 32'h0000_0100, c);
    bus_rd(8'h00, 32'h0000_0240, "R3", "clear alias drops PS bit 8");
    bus_wr(8'h04, 4'b0001, 32'h0000_0001, c);
    bus_rd(8'h00, 32'h0000_0241, "R3", "set alias raises window");
    bus_wr(8'h08, 4'b0001, 32'h0000_0001, c);
    bus_rd(8'h00, 32'h0000_0240, "R3", "clear alias drops window");

    // R11 disabled: no request may appear (monitor)
    idle(300);

    // R4 enable with PS=2: expiry 128 cycles later
    bus_wr(8'h04, 4'b0010, 32'h0000_8000, c);
    exp_q.push_back(c + 128);
    wait_until(c + 130);
    bus_rd(8'h00, 32'h0000_8240, "R4", "control while running");
    bus_rd(8'h10, 32'h0000_0010, "R9", "flag after expiry");
    idle(300);                 // R8 parked: monitor flags any extra pulse
    bus_rd(8'h10, 32'h0000_0010, "R9", "flag still set");

    // R9 / R3 status aliases
    bus_wr(8'h18, 4'b0001, 32'h0000_0010, c);
    bus_rd(8'h10, 32'h0, "R9", "flag cleared via clear alias");
    bus_wr(8'h14, 4'b0001, 32'h0000_0010, c);
    bus_rd(8'h10, 32'h0000_0010, "R3", "flag set via set alias");
    bus_wr(8'h18, 4'b0001, 32'h0000_0010, c);

    // R5 repeated key at byte address 0x02 restarts the count
    bus_wr(8'h02, 4'b1100, 32'h5743_0000, c);
    idle(60);
    bus_wr(8'h02, 4'b1100, 32'h5743_0000, c2);
    exp_q.push_back(c2 + 128);
    wait_until(c2 + 130);
    bus_wr(8'h18, 4'b0001, 32'h0000_0010, c);

    // R6 wrong key and full-word key do not restart
    bus_wr(8'h00, 4'b1100, 32'h5743_0000, c2);
    exp_q.push_back(c2 + 128);
    idle(40);
    bus_wr(8'h02, 4'b1100, 32'h1234_0000, c);
    idle(20);
    bus_wr(8'h00, 4'b1111, 32'h5743_8240, c);
    wait_until(c2 + 130);
    bus_rd(8'h00, 32'h0000_8240, "R6", "control after full-word key");

    // R10 write in the cycle after disable is dropped
    bus_wr(8'h08, 4'b0010, 32'h0000_8000, c);
    bus_wr(8'h04, 4'b0001, 32'h0000_0001, c);
    bus_rd(8'h00, 32'h0000_0240, "R10", "write in blackout ignored");
    bus_wr(8'h04, 4'b0001, 32'h0000_0001, c);
    bus_rd(8'h00, 32'h0000_0241, "R10", "write accepted afterwards");
    bus_wr(8'h08, 4'b0001, 32'h0000_0001, c);

    // R7 re-enable restarts from zero (early pulse would be caught)
    bus_wr(8'h04, 4'b0010, 32'h0000_8000, c);
    idle(60);
    bus_wr(8'h08, 4'b0010, 32'h0000_8000, c);
    idle(5);
    bus_wr(8'h04, 4'b0010, 32'h0000_8000, c2);
    exp_q.push_back(c2 + 128);
    wait_until(c2 + 130);

    // R4 PS=0 corner and R9 expiry beating a same-cycle clear
    bus_wr(8'h18, 4'b0001, 32'h0000_0010, c);
    bus_wr(8'h08, 4'b0010, 32'h0000_8000, c);
    idle(1);
    bus_wr(8'h08, 4'b0010, 32'h0000_1F00, c);
    bus_rd(8'h00, 32'h0000_0040, "R3", "exponent cleared");
    bus_wr(8'h04, 4'b0010, 32'h0000_8000, c2);
    exp_q.push_back(c2 + 32);
    wait_until(c2 + 31);
    bus_wr(8'h18, 4'b0001, 32'h0000_0010, c);
    bus_rd(8'h10, 32'h0000_0010, "R9", "expiry wins over clear");
    bus_wr(8'h18, 4'b0001, 32'h0000_0010, c);
    bus_rd(8'h10, 32'h0, "R9", "flag cleared later");

    idle(5);
    chk(exp_q.size() == 0, "R4", "pending expected requests", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule